// File: doc/BRIEF.md
# Address-Dependent CPU Clock Rate Selector

This block divides a master clock into the two quadrature phase signals of a processor bus cycle, E and Q, plus a one-clock marker at the start of every bus cycle. Each bus cycle lasts either 16 master clocks (slow) or 8 master clocks (fast). The choice comes from a 2-bit rate field, a map-type bit and a ROM-select input. The ROM-select input comes from an address decoder outside this block, which asserts it for the ROM window $8000-$FEFF while the map-type bit is 0.

In address-dependent mode, the length of each bus cycle follows the target of that cycle: ROM cycles run fast and RAM cycles run slow. The ratio can therefore change from one cycle to the next. A new ratio takes effect only on a cycle boundary, so no phase is ever cut short. Setting the map-type bit to 1 deselects ROM and forces slow operation whatever the rate field holds.

Top module: `clkrate_gen`

## Requirements
- R1: While reset is held, E and Q are low and the cycle-start marker is high. The first bus cycle after reset is slow, lasting 16 master clocks.
- R2: A rate field of 00 with the map-type bit at 0 gives 16-clock cycles, whatever ROM-select is.
- R3: A rate field of 10 or 11 with the map-type bit at 0 gives 8-clock cycles, whatever ROM-select is.
- R4: A rate field of 01 with the map-type bit at 0 gives an 8-clock cycle when ROM-select is 1 and a 16-clock cycle when ROM-select is 0.
- R5: When the map-type bit is 1, every cycle lasts 16 clocks, whatever the rate field or ROM-select is.
- R6: Master clocks within a cycle of length N are numbered from k=0 at the clock where the cycle-start marker is high. Q is high for N/4 <= k < 3N/4, E is high for N/2 <= k < N, and the marker is high only at k=0. Q therefore leads E by N/4.
- R7: The length of a cycle is set only by the inputs present on the last master clock of the cycle before it. Input changes at any other point in that earlier cycle have no effect on either cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate | input | 2 | Rate field: 00 slow, 01 address-dependent, 10 fast, 11 fast |
| map_ram | input | 1 | Map-type bit; 1 deselects ROM and forces slow cycles |
| rom_sel | input | 1 | High when the upcoming bus cycle targets ROM |
| e_phase | output | 1 | E phase level |
| q_phase | output | 1 | Q phase level, leading E by a quarter cycle |
| cyc_start | output | 1 | High on the first master clock of every bus cycle |

## Verification
The hardest case to reach is a ratio change that must be ignored: an input swing in the middle of a cycle that goes back to its old value before the cycle's last clock. A directed cycle flips the inputs to fast two clocks into a slow cycle and restores them three clocks before its end. The bench then checks that the next cycle still runs at the restored ratio. Randomised cycles with a fixed seed alternate freely between 8-clock and 16-clock lengths. This exercises back-to-back ratio changes in both directions, including address-dependent cycles that toggle between ROM and RAM.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW  = 2'b00,
    RATE_ADDR  = 2'b01,
    RATE_FAST  = 2'b10,
    RATE_TURBO = 2'b11
  } rate_e;

  // Decide whether the next bus cycle runs at the fast ratio.
  function automatic logic pick_fast(input rate_e rate, input logic map_ram,
                                     input logic rom_hit);
    logic fast;
    if (map_ram) begin
      fast = 1'b0;
    end else begin
      unique case (rate)
        RATE_SLOW:  fast = 1'b0;
        RATE_ADDR:  fast = rom_hit;
        RATE_FAST:  fast = 1'b1;
        RATE_TURBO: fast = 1'b1;
        default:    fast = 1'b0;
      endcase
    end
    return fast;
  endfunction

endpackage

// File: rtl/clkrate_select.sv
module clkrate_select
  import clkrate_pkg::*;
(
  input  logic [1:0] rate,
  input  logic       map_ram,
  input  logic       rom_sel,
  output logic       fast_next
);

  always_comb begin
    fast_next = pick_fast(rate_e'(rate), map_ram, rom_sel);
  end

endmodule

// File: rtl/clkrate_counter.sv
module clkrate_counter #(
  parameter int SLOW_DIV = 16,
  parameter int FAST_DIV = 8,
  parameter int CNT_W    = $clog2(SLOW_DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_next,
  output logic [CNT_W-1:0] cnt,
  output logic             fast_q,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);

  assign at_last = (cnt == (fast_q ? FAST_LAST : SLOW_LAST));

  // The ratio register loads only on the last clock of a cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      fast_q <= 1'b0;
    end else if (at_last) begin
      cnt    <= '0;
      fast_q <= fast_next;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !at_last |=> $stable(fast_q));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> (cnt == '0));

  assert_fast_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fast_q |-> (cnt <= FAST_LAST));

endmodule

// File: rtl/clkrate_phase.sv
module clkrate_phase #(
  parameter int SLOW_DIV = 16,
  parameter int FAST_DIV = 8,
  parameter int CNT_W    = $clog2(SLOW_DIV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             fast_q,
  output logic             e_phase,
  output logic             q_phase,
  output logic             cyc_start
);

  localparam logic [CNT_W-1:0] S_Q_ON  = CNT_W'(SLOW_DIV / 4);
  localparam logic [CNT_W-1:0] S_Q_OFF = CNT_W'((SLOW_DIV / 4) * 3);
  localparam logic [CNT_W-1:0] S_E_ON  = CNT_W'(SLOW_DIV / 2);
  localparam logic [CNT_W-1:0] F_Q_ON  = CNT_W'(FAST_DIV / 4);
  localparam logic [CNT_W-1:0] F_Q_OFF = CNT_W'((FAST_DIV / 4) * 3);
  localparam logic [CNT_W-1:0] F_E_ON  = CNT_W'(FAST_DIV / 2);

  logic [CNT_W-1:0] q_on, q_off, e_on;

  always_comb begin
    q_on  = fast_q ? F_Q_ON  : S_Q_ON;
    q_off = fast_q ? F_Q_OFF : S_Q_OFF;
    e_on  = fast_q ? F_E_ON  : S_E_ON;
    q_phase   = (cnt >= q_on) && (cnt < q_off);
    e_phase   = (cnt >= e_on);
    cyc_start = (cnt == '0);
  end

  assert_q_leads_e_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_phase) |-> q_phase);

  assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (!e_phase && !q_phase));

  assert_q_falls_in_e_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_phase) |-> e_phase);

endmodule

// File: rtl/clkrate_gen.sv
module clkrate_gen #(
  parameter int SLOW_DIV = 16,
  parameter int FAST_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate,
  input  logic       map_ram,
  input  logic       rom_sel,
  output logic       e_phase,
  output logic       q_phase,
  output logic       cyc_start
);

  localparam int CNT_W = $clog2(SLOW_DIV);

  logic             fast_next;
  logic [CNT_W-1:0] cnt;
  logic             ratio_fast;
  logic             at_last;

  clkrate_select u_select (
    .rate      (rate),
    .map_ram   (map_ram),
    .rom_sel   (rom_sel),
    .fast_next (fast_next)
  );

  clkrate_counter #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .CNT_W    (CNT_W)
  ) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_next (fast_next),
    .cnt       (cnt),
    .fast_q    (ratio_fast),
    .at_last   (at_last)
  );

  clkrate_phase #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .CNT_W    (CNT_W)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt),
    .fast_q    (ratio_fast),
    .e_phase   (e_phase),
    .q_phase   (q_phase),
    .cyc_start (cyc_start)
  );

  assert_map_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && $past(at_last) && $past(map_ram)) |-> !ratio_fast);

  assert_rom_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && $past(at_last) && $past(rate == 2'b01 && !map_ram && rom_sel))
      |-> ratio_fast);

  assert_slow_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && $past(at_last) && $past(rate == 2'b00)) |-> !ratio_fast);

endmodule

// File: tb/test_clkrate_gen.sv
module test_clkrate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate = 2'b00;
  logic       map_ram = 1'b0;
  logic       rom_sel = 1'b0;
  logic       e_phase, q_phase, cyc_start;

  int checks = 0;
  int fails = 0;
  int exp_n = 16;
  string exp_req = "R1";

  always #5 clk = ~clk;

  clkrate_gen i_clkrate_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate      (rate),
    .map_ram   (map_ram),
    .rom_sel   (rom_sel),
    .e_phase   (e_phase),
    .q_phase   (q_phase),
    .cyc_start (cyc_start)
  );

  function automatic int want_div(logic [1:0] r, logic m, logic rom);
    if (m) return 16;
    if (r == 2'b00) return 16;
    if (r == 2'b01) return rom ? 8 : 16;
    return 8;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Entered at a negedge where cyc_start is high. Sets the inputs for the
  // following cycle and measures the current one.
  task automatic run_cycle(input logic [1:0] r, input logic m, input logic rom,
                           input bit glitch, input string req);
    int k;
    bit shape_ok;
    int bad_k;
    rate = r; map_ram = m; rom_sel = rom;
    k = 0; shape_ok = 1'b1; bad_k = -1;
    do begin
      if (e_phase !== (k >= exp_n / 2) ||
          q_phase !== (k >= exp_n / 4 && k < (3 * exp_n) / 4) ||
          cyc_start !== (k == 0)) begin
        shape_ok = 1'b0; bad_k = k;
      end
      if (glitch && k == 2) begin
        rate = 2'b10; map_ram = 1'b0; rom_sel = 1'b1;
      end
      if (glitch && k == exp_n - 3) begin
        rate = r; map_ram = m; rom_sel = rom;
      end
      @(negedge clk);
      k++;
    end while (!cyc_start && k <= 40);
    check(k == exp_n, exp_req, k, exp_n);
    check(shape_ok, "R6", bad_k, -1);
    exp_n = want_div(r, m, rom);
    exp_req = req;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rate = 2'b10; rom_sel = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(e_phase == 1'b0, "R1", e_phase, 0);
    check(q_phase == 1'b0, "R1", q_phase, 0);
    check(cyc_start == 1'b1, "R1", cyc_start, 1);
    rst_n = 1'b1;
    check(cyc_start == 1'b1, "R1", cyc_start, 1);

    run_cycle(2'b00, 1'b0, 1'b1, 1'b0, "R2");
    run_cycle(2'b10, 1'b0, 1'b0, 1'b0, "R3");
    run_cycle(2'b11, 1'b0, 1'b1, 1'b0, "R3");
    run_cycle(2'b01, 1'b0, 1'b1, 1'b0, "R4");
    run_cycle(2'b01, 1'b0, 1'b0, 1'b0, "R4");
    run_cycle(2'b01, 1'b0, 1'b1, 1'b0, "R4");
    run_cycle(2'b10, 1'b1, 1'b1, 1'b0, "R5");
    run_cycle(2'b01, 1'b1, 1'b1, 1'b0, "R5");
    run_cycle(2'b11, 1'b1, 1'b0, 1'b0, "R5");
    // R7: mid-cycle swing to fast inputs, restored before the last clock
    run_cycle(2'b00, 1'b0, 1'b0, 1'b1, "R7");
    run_cycle(2'b10, 1'b0, 1'b0, 1'b0, "R3");
    run_cycle(2'b01, 1'b0, 1'b0, 1'b1, "R7");

    for (int i = 0; i < 80; i++) begin
      logic [1:0] r;
      logic m, rom;
      r   = 2'($urandom_range(0, 3));
      m   = ($urandom_range(0, 3) == 0);
      rom = 1'($urandom_range(0, 1));
      if (m) run_cycle(r, m, rom, 1'($urandom_range(0, 1)), "R5");
      else if (r == 2'b00) run_cycle(r, m, rom, 1'b0, "R2");
      else if (r == 2'b01) run_cycle(r, m, rom, 1'b0, "R4");
      else run_cycle(r, m, rom, 1'b0, "R3");
    end
    run_cycle(2'b00, 1'b0, 1'b0, 1'b0, "R2");
    finish_run();
  end

endmodule